// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block turns a single active-low external interrupt pin into a maskable interrupt request for the CPU. The pin passes through a synchronizer clocked by the system clock. A falling edge of the synchronized level sets an interrupt flag. The flag is cleared in one of two ways: by the CPU's vector-fetch strobe, or by software writing a one to an acknowledge bit.

A mode bit picks between two senses. In edge-only sense, the flag clears on the first acknowledge. In edge-plus-level sense, the flag stays set as long as the pin stays low. It clears only once an acknowledge has happened and the pin has also gone back high, and these two can occur in either order.

A mask bit hides the flag from the request output without discarding it. The synchronized pin level is also supplied to the CPU for pin-test branch instructions.

Software reaches the block through one 8-bit register on a single-cycle bus port.

Top module: `ext_irq_ctrl`

## Requirements
- R1: `pin_level` equals the value `irq_pin_n` held two clock edges earlier, and it reads 1 during and right after reset.
- R2: A falling edge on the pin sets the flag (register bit 3). The flag and `irq_req` are high after the third rising clock edge that follows the pin going low, and not after the second.
- R3: With the mode bit (bit 0) at 0, a bus write with bit 2 set clears the flag and drops `irq_req` at that write's clock edge.
- R4: With the mode bit at 0, a one-cycle `vec_fetch` pulse clears the flag.
- R5: With the mode bit at 1, an acknowledge given while the pin is low leaves the flag and `irq_req` set. The flag clears once the pin returns high.
- R6: With the mode bit at 1, a pin that returns high without any acknowledge keeps the flag set. A later acknowledge then clears it.
- R7: With the mask bit (bit 1) at 1, `irq_req` stays low while the flag stays latched. Clearing the mask presents the pending request.
- R8: Register layout: bits 7..4 read 0, bit 2 always reads 0, and bits 1 and 0 read back the last value written. Writes happen only when `bus_sel` and `bus_we` are both high.
- R9: Reset clears the flag and the mode bit even while the pin is held low. A pin that is still low when reset is released is not taken as a new edge.
- R10: When an acknowledge and a new falling edge arrive in the same cycle, the flag stays set.
- R11: With the mode bit at 0, a pin that stays low after an acknowledge does not raise the flag again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pin_n | input | 1 | Asynchronous active-low interrupt pin |
| bus_sel | input | 1 | Register address match |
| bus_we | input | 1 | Write enable, used together with `bus_sel` |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Register contents |
| vec_fetch | input | 1 | One-cycle strobe for the interrupt vector fetch |
| irq_req | output | 1 | Interrupt request to the CPU, active high |
| pin_level | output | 1 | Synchronized pin level for branch-on-pin tests |

## Verification
The hardest case to reach from the ports is an acknowledge that lands in the exact cycle a new falling edge is detected. The edge only appears two clock edges after the pin moves. So the bench first latches a request and returns the pin high. It then drops the pin again and places the acknowledge write precisely two cycles later. The two level-sense orderings are driven separately, acknowledge-then-release and release-then-acknowledge, and the flag is sampled between the two events in each.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int REG_W     = 8;
  localparam int BIT_FLAG  = 3;
  localparam int BIT_ACK   = 2;
  localparam int BIT_MASK  = 1;
  localparam int BIT_SENSE = 0;

  typedef struct packed {
    logic flag;
    logic mask;
    logic sense;
  } irq_state_t;

  // Pack the visible state into the register image.
  function automatic logic [REG_W-1:0] pack_reg(irq_state_t s);
    logic [REG_W-1:0] r;
    r            = '0;
    r[BIT_FLAG]  = s.flag;
    r[BIT_MASK]  = s.mask;
    r[BIT_SENSE] = s.sense;
    return r;
  endfunction

  // Next flag / acknowledged-state for the request latch.
  function automatic logic [1:0] latch_next(logic flag, logic seen, logic fall,
                                            logic clr, logic sense, logic pin_hi);
    logic done;
    done = seen | clr;
    if (fall)                   return 2'b10;
    else if (!flag)             return 2'b00;
    else if (sense && !pin_hi)  return {1'b1, done};
    else if (done)              return 2'b00;
    else                        return 2'b10;
  endfunction
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic level,
  output logic fall
);
  localparam int ARM_MAX = STAGES + 1;
  localparam int CW      = $clog2(ARM_MAX + 1);

  logic [STAGES-1:0] shreg;
  logic              prev;
  logic [CW-1:0]     arm_cnt;
  logic              armed;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '1;
        else        shreg <= pin_n;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '1;
        else        shreg <= {shreg[STAGES-2:0], pin_n};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev    <= 1'b1;
      arm_cnt <= '0;
    end else begin
      prev <= shreg[STAGES-1];
      if (arm_cnt != CW'(ARM_MAX)) arm_cnt <= arm_cnt + 1'b1;
    end
  end

  assign armed = (arm_cnt == CW'(ARM_MAX));
  assign level = shreg[STAGES-1];
  assign fall  = armed & prev & ~shreg[STAGES-1];
endmodule

// File: rtl/irq_latch.sv
module irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic fall,
  input  logic clr,
  input  logic sense,
  input  logic pin_hi,
  output logic flag,
  output logic seen
);
  import irq_pkg::*;
  logic [1:0] nxt;

  always_comb nxt = latch_next(flag, seen, fall, clr, sense, pin_hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
      seen <= 1'b0;
    end else begin
      flag <= nxt[1];
      seen <= nxt[0];
    end
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sel,
  input  logic                     we,
  input  logic [irq_pkg::REG_W-1:0] wdata,
  input  logic                     flag,
  output logic [irq_pkg::REG_W-1:0] rdata,
  output logic                     mask,
  output logic                     sense,
  output logic                     ack_wr
);
  import irq_pkg::*;
  logic       wr;
  irq_state_t st;

  assign wr     = sel & we;
  assign ack_wr = wr & wdata[BIT_ACK];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask  <= 1'b0;
      sense <= 1'b0;
    end else if (wr) begin
      mask  <= wdata[BIT_MASK];
      sense <= wdata[BIT_SENSE];
    end
  end

  always_comb begin
    st.flag  = flag;
    st.mask  = mask;
    st.sense = sense;
    rdata    = pack_reg(st);
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irq_pin_n,
  input  logic       bus_sel,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       vec_fetch,
  output logic       irq_req,
  output logic       pin_level
);
  logic fall_evt, clr_evt, ack_wr;
  logic flag_q, seen_q, mask_q, sense_q;

  irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_n(irq_pin_n),
    .level(pin_level), .fall(fall_evt)
  );

  irq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .we(bus_we), .wdata(bus_wdata),
    .flag(flag_q), .rdata(bus_rdata), .mask(mask_q), .sense(sense_q),
    .ack_wr(ack_wr)
  );

  assign clr_evt = ack_wr | vec_fetch;

  irq_latch u_latch (
    .clk(clk), .rst_n(rst_n), .fall(fall_evt), .clr(clr_evt),
    .sense(sense_q), .pin_hi(pin_level), .flag(flag_q), .seen(seen_q)
  );

  assign irq_req = flag_q & ~mask_q;
endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker (
  input logic clk,
  input logic rst_n,
  input logic fall_evt,
  input logic clr_evt,
  input logic flag_q,
  input logic seen_q,
  input logic mask_q,
  input logic sense_q,
  input logic pin_level,
  input logic irq_req
);
  assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> flag_q);

  assert_edge_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sense_q && flag_q && clr_evt && !fall_evt) |=> !flag_q);

  assert_level_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_q && flag_q && !pin_level) |=> flag_q);

  assert_mask_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |-> !irq_req);

  assert_req_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> flag_q);

  assert_no_spurious_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_evt && !seen_q) |=> flag_q);

  assert_edge_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && clr_evt) |=> flag_q);
endmodule

bind ext_irq_ctrl irq_ctrl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .fall_evt(fall_evt), .clr_evt(clr_evt),
  .flag_q(flag_q), .seen_q(seen_q), .mask_q(mask_q), .sense_q(sense_q),
  .pin_level(pin_level), .irq_req(irq_req)
);

// File: tb/tb_ext_irq_ctrl.sv
`timescale 1ns/1ps
module tb_ext_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       irq_pin_n = 1'b1;
  logic       bus_sel = 1'b0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       vec_fetch = 1'b0;
  logic       irq_req;
  logic       pin_level;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  ext_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .vec_fetch(vec_fetch), .irq_req(irq_req), .pin_level(pin_level)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_wdata = d;
    tick(1);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic fire_edge();
    irq_pin_n = 1'b0; tick(3);
    irq_pin_n = 1'b1; tick(3);
  endtask

  task automatic t_reset();
    chk("R9 reset reg", bus_rdata, 8'h00);
    chk("R9 reset req", {7'd0, irq_req}, 8'h00);
    chk("R1 reset level", {7'd0, pin_level}, 8'h01);
  endtask

  task automatic t_sync_edge();
    irq_pin_n = 1'b0;
    tick(1); chk("R1 level after 1", {7'd0, pin_level}, 8'h01);
    tick(1); chk("R1 level after 2", {7'd0, pin_level}, 8'h00);
    chk("R2 not yet set", bus_rdata, 8'h00);
    tick(1); chk("R2 flag set", bus_rdata, 8'h08);
    chk("R2 req", {7'd0, irq_req}, 8'h01);
    irq_pin_n = 1'b1; tick(3);
  endtask

  task automatic t_ack();
    wr(8'h04);
    chk("R3 ack clears", bus_rdata, 8'h00);
    chk("R3 req low", {7'd0, irq_req}, 8'h00);
  endtask

  task automatic t_vec();
    fire_edge();
    chk("R4 flag before", bus_rdata, 8'h08);
    vec_fetch = 1'b1; tick(1); vec_fetch = 1'b0;
    chk("R4 vector clears", bus_rdata, 8'h00);
  endtask

  task automatic t_edge_low();
    irq_pin_n = 1'b0; tick(3);
    wr(8'h04);
    tick(5);
    chk("R11 low pin no rearm", bus_rdata, 8'h00);
    irq_pin_n = 1'b1; tick(3);
  endtask

  task automatic t_level_ack_first();
    wr(8'h01);
    irq_pin_n = 1'b0; tick(3);
    wr(8'h05);
    tick(2);
    chk("R5 held while low", bus_rdata, 8'h09);
    chk("R5 req held", {7'd0, irq_req}, 8'h01);
    irq_pin_n = 1'b1; tick(3);
    chk("R5 clears on release", bus_rdata, 8'h01);
  endtask

  task automatic t_level_pin_first();
    irq_pin_n = 1'b0; tick(3);
    irq_pin_n = 1'b1; tick(4);
    chk("R6 held without ack", bus_rdata, 8'h09);
    wr(8'h05);
    chk("R6 ack clears", bus_rdata, 8'h01);
    wr(8'h00);
  endtask

  task automatic t_mask();
    wr(8'h02);
    fire_edge();
    chk("R7 masked req", {7'd0, irq_req}, 8'h00);
    chk("R7 still latched", bus_rdata, 8'h0A);
    wr(8'h00);
    chk("R7 unmask presents", {7'd0, irq_req}, 8'h01);
    wr(8'h04);
  endtask

  task automatic t_layout();
    wr(8'hF3);
    chk("R8 upper bits zero", bus_rdata, 8'h03);
    wr(8'hFF);
    chk("R8 ack reads zero", bus_rdata, 8'h03);
    bus_sel = 1'b0; bus_we = 1'b1; bus_wdata = 8'h00; tick(1);
    bus_we = 1'b0;
    chk("R8 no write unselected", bus_rdata, 8'h03);
    wr(8'h00);
  endtask

  task automatic t_collide();
    fire_edge();
    irq_pin_n = 1'b0; tick(2);
    bus_sel = 1'b1; bus_we = 1'b1; bus_wdata = 8'h04;
    tick(1);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = 8'h00;
    chk("R10 edge wins", bus_rdata, 8'h08);
    irq_pin_n = 1'b1; tick(3);
    wr(8'h04);
  endtask

  task automatic t_reset_low();
    wr(8'h01);
    irq_pin_n = 1'b0; tick(3);
    chk("R9 set before reset", bus_rdata, 8'h09);
    rst_n = 1'b0; tick(2);
    rst_n = 1'b1; tick(6);
    chk("R9 reset drops", bus_rdata, 8'h00);
    chk("R9 req low", {7'd0, irq_req}, 8'h00);
    irq_pin_n = 1'b1; tick(3);
  endtask

  initial begin
    #1ms;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_sync_edge();
    t_ack();
    t_vec();
    t_edge_low();
    t_level_ack_first();
    t_level_pin_first();
    t_mask();
    t_layout();
    t_collide();
    t_reset_low();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule